// File: doc/BRIEF.md
# Level-2 Decision Handshake Controller

This controller pairs each level-1 accept with the decision word that a processor returns for that event. The accept carries a 2-bit buffer number and an 8-bit bunch count. The decision word carries its own copy of both fields and a pass flag. The two may arrive in either order or in the same cycle. Once both are held, the controller waits for a programmable delay. It then offers one outcome to the trigger supervisor: accept, reject or timeout. The offer stays up until the supervisor acknowledges it. The controller rearms only after the acknowledge has been released.

An accept with no decision behind it runs a programmable timeout and then reports a timeout outcome. The buffer number and bunch count of the decision are compared with those of the accept. Any difference turns the outcome into a reject and sets a sticky error flag. Every completed handshake writes one record into a small readout RAM at consecutive addresses. The RAM can be read through a synchronous port.

States: `ST_ARMED` is idle and waiting. `ST_WAIT_DEC` holds the accept and runs the timeout. `ST_WAIT_L1A` holds an early decision. `ST_DELAY` counts the output delay. `ST_OFFER` drives the outcome. `ST_RELEASE` waits for the acknowledge to drop. The transitions are:
- armed to wait_dec on an accept alone;
- armed to wait_l1a on a decision alone;
- armed to delay on both together;
- wait_dec to delay on a decision;
- wait_dec to offer on expiry;
- wait_l1a to delay on an accept;
- delay to offer when the count is reached;
- offer to release on acknowledge;
- release to armed when the acknowledge is low.

Top module: `l2_decision_ctrl`

## Requirements
- R1: After reset `sup_req` is low, `sup_code` is 2'b00 and `err_flag` is low.
- R2: No outcome is offered until both an accept and a decision have been taken, in either order or together; a decision alone never produces an outcome.
- R3: `sup_req` rises exactly `delay_cfg`+1 clock edges after the edge at which the second of the two inputs is taken.
- R4: An accept with no decision offers code 2'b11 (timeout) exactly `timeout_cfg`+1 edges after the accept edge; a decision taken at that final edge wins over the timeout.
- R5: With matching fields the code is 2'b01 (accept) when the pass flag is 1 and 2'b10 (reject) when it is 0; `sup_code` is 2'b00 whenever `sup_req` is low.
- R6: A buffer-number or bunch-count mismatch gives code 2'b10 and sets `err_flag` at the acknowledge; `err_flag` then stays high until reset.
- R7: `sup_req` and `sup_code` hold steady until `sup_ack` is seen, and `sup_req` is low the cycle after the acknowledging edge.
- R8: After the acknowledge, the controller ignores accepts and decisions until `sup_ack` returns low.
- R9: Each acknowledge writes one 13-bit record to the next RAM address, starting at 0: bits [12:11] are the accept's buffer number, [10:3] its bunch count, [2:1] the outcome code and [0] the mismatch bit. The record is read back one cycle after `rec_raddr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1a_valid | input | 1 | Level-1 accept strobe |
| l1a_buf | input | 2 | Buffer number of the accept |
| l1a_bunch | input | 8 | Bunch count of the accept |
| dec_valid | input | 1 | Decision word strobe |
| dec_buf | input | 2 | Buffer number in the decision |
| dec_bunch | input | 8 | Bunch count in the decision |
| dec_pass | input | 1 | Decision pass flag |
| delay_cfg | input | DLY_W | Output delay setting |
| timeout_cfg | input | TO_W | Decision timeout setting |
| sup_req | output | 1 | Outcome offered to the supervisor |
| sup_code | output | 2 | Outcome code |
| sup_ack | input | 1 | Supervisor acknowledge |
| err_flag | output | 1 | Sticky mismatch flag |
| rec_raddr | input | AW | Readout RAM read address |
| rec_rdata | output | 13 | Readout RAM read data |

## Verification
The hardest case to reach is a decision that arrives on the very edge at which the timeout counter expires. In that case the decision must win. The stimulus sets a known timeout, counts edges from the accept, and presents the decision on exactly the expiry edge. A second hard case is traffic that arrives while the acknowledge is still held. The bench sends an accept and a decision together during release. It then shows that no outcome follows once the acknowledge drops.

// File: rtl/l2hs_pkg.sv
package l2hs_pkg;
    localparam int BUF_W = 2;
    localparam int BX_W  = 8;
    localparam int REC_W = BUF_W + BX_W + 3;

    typedef enum logic [1:0] {
        OUT_NONE    = 2'b00,
        OUT_ACCEPT  = 2'b01,
        OUT_REJECT  = 2'b10,
        OUT_TIMEOUT = 2'b11
    } outcome_e;

    typedef enum logic [2:0] {
        ST_ARMED,
        ST_WAIT_DEC,
        ST_WAIT_L1A,
        ST_DELAY,
        ST_OFFER,
        ST_RELEASE
    } state_e;

    typedef struct packed {
        logic [BUF_W-1:0] buf_id;
        logic [BX_W-1:0]  bunch;
        outcome_e         code;
        logic             mismatch;
    } rec_t;
endpackage

// File: rtl/l2hs_cycle_cnt.sv
module l2hs_cycle_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (en)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/l2hs_rec_ram.sv
module l2hs_rec_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 13,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/l2_decision_ctrl.sv
module l2_decision_ctrl
    import l2hs_pkg::*;
#(
    parameter int DLY_W = 8,
    parameter int TO_W  = 10,
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = (DLY_W > TO_W) ? DLY_W : TO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1a_valid,
    input  logic [BUF_W-1:0] l1a_buf,
    input  logic [BX_W-1:0]  l1a_bunch,
    input  logic             dec_valid,
    input  logic [BUF_W-1:0] dec_buf,
    input  logic [BX_W-1:0]  dec_bunch,
    input  logic             dec_pass,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [TO_W-1:0]  timeout_cfg,
    output logic             sup_req,
    output logic [1:0]       sup_code,
    input  logic             sup_ack,
    output logic             err_flag,
    input  logic [AW-1:0]    rec_raddr,
    output logic [REC_W-1:0] rec_rdata
);
    state_e state, state_n;

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_en;
    logic [CNT_W-1:0] dly_lim, to_lim;

    logic [BUF_W-1:0] hold_l1_buf, hold_dec_buf;
    logic [BX_W-1:0]  hold_l1_bx, hold_dec_bx;
    logic             hold_pass;
    logic             timed_out;
    logic             mismatch;
    outcome_e         outcome;

    logic             rec_we;
    logic [AW-1:0]    wptr;
    rec_t             rec_w;

    assign dly_lim = CNT_W'(delay_cfg);
    assign to_lim  = CNT_W'(timeout_cfg);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARMED;
        else
            state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_ARMED: begin
                if (l1a_valid && dec_valid) state_n = ST_DELAY;
                else if (l1a_valid)         state_n = ST_WAIT_DEC;
                else if (dec_valid)         state_n = ST_WAIT_L1A;
            end
            ST_WAIT_DEC: begin
                if (dec_valid)          state_n = ST_DELAY;
                else if (cnt == to_lim) state_n = ST_OFFER;
            end
            ST_WAIT_L1A: begin
                if (l1a_valid) state_n = ST_DELAY;
            end
            ST_DELAY: begin
                if (cnt == dly_lim) state_n = ST_OFFER;
            end
            ST_OFFER: begin
                if (sup_ack) state_n = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!sup_ack) state_n = ST_ARMED;
            end
            default: state_n = ST_ARMED;
        endcase
    end

    // shared delay / timeout counter, restarted at every state change
    assign cnt_clr = (state_n != state);
    assign cnt_en  = (state == ST_WAIT_DEC) || (state == ST_DELAY);

    l2hs_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .count (cnt)
    );

    // capture of the accept and the decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l1_buf  <= '0;
            hold_l1_bx   <= '0;
            hold_dec_buf <= '0;
            hold_dec_bx  <= '0;
            hold_pass    <= 1'b0;
            timed_out    <= 1'b0;
        end else begin
            if (l1a_valid && (state == ST_ARMED || state == ST_WAIT_L1A)) begin
                hold_l1_buf <= l1a_buf;
                hold_l1_bx  <= l1a_bunch;
            end
            if (dec_valid && (state == ST_ARMED || state == ST_WAIT_DEC)) begin
                hold_dec_buf <= dec_buf;
                hold_dec_bx  <= dec_bunch;
                hold_pass    <= dec_pass;
            end
            if (state == ST_ARMED)
                timed_out <= 1'b0;
            else if (state == ST_WAIT_DEC && !dec_valid && cnt == to_lim)
                timed_out <= 1'b1;
        end
    end

    assign mismatch = !timed_out &&
                      ((hold_l1_buf != hold_dec_buf) || (hold_l1_bx != hold_dec_bx));

    always_comb begin
        if (timed_out)     outcome = OUT_TIMEOUT;
        else if (mismatch) outcome = OUT_REJECT;
        else if (hold_pass) outcome = OUT_ACCEPT;
        else               outcome = OUT_REJECT;
    end

    // output decode
    always_comb begin
        sup_req  = (state == ST_OFFER);
        sup_code = sup_req ? outcome : OUT_NONE;
        rec_we   = (state == ST_OFFER) && sup_ack;
    end

    // sticky error and record write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            wptr     <= '0;
        end else if (rec_we) begin
            if (mismatch)
                err_flag <= 1'b1;
            if (wptr == AW'(DEPTH - 1))
                wptr <= '0;
            else
                wptr <= wptr + 1'b1;
        end
    end

    assign rec_w = '{buf_id: hold_l1_buf, bunch: hold_l1_bx, code: outcome, mismatch: mismatch};

    l2hs_rec_ram #(.DEPTH(DEPTH), .W(REC_W)) u_ram (
        .clk   (clk),
        .we    (rec_we),
        .waddr (wptr),
        .wdata (rec_w),
        .raddr (rec_raddr),
        .rdata (rec_rdata)
    );
endmodule

// File: rtl/l2hs_checker.sv
module l2hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_req,
    input logic [1:0] sup_code,
    input logic       sup_ack,
    input logic       err_flag,
    input logic       rec_we
);
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_req && !sup_ack) |=> sup_req);

    a_r7_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_req && !sup_ack) |=> $stable(sup_code));

    a_r7_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_req && sup_ack) |=> !sup_req);

    a_r5_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sup_req |-> (sup_code != 2'b00));

    a_r5_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_req |-> (sup_code == 2'b00));

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    a_r9_write_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> (sup_req && sup_ack));

    a_r8_quiet_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_req && sup_ack) |=> !sup_req);
endmodule

bind l2_decision_ctrl l2hs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_req  (sup_req),
    .sup_code (sup_code),
    .sup_ack  (sup_ack),
    .err_flag (err_flag),
    .rec_we   (rec_we)
);

// File: tb/l2_decision_ctrl_test.sv
`timescale 1ns/1ps
module l2_decision_ctrl_test;
    localparam int DLY_W = 8;
    localparam int TO_W  = 10;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int TO_SET = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             l1a_valid = 1'b0;
    logic [1:0]       l1a_buf = '0;
    logic [7:0]       l1a_bunch = '0;
    logic             dec_valid = 1'b0;
    logic [1:0]       dec_buf = '0;
    logic [7:0]       dec_bunch = '0;
    logic             dec_pass = 1'b0;
    logic [DLY_W-1:0] delay_cfg = '0;
    logic [TO_W-1:0]  timeout_cfg = TO_W'(TO_SET);
    logic             sup_req;
    logic [1:0]       sup_code;
    logic             sup_ack = 1'b0;
    logic             err_flag;
    logic [AW-1:0]    rec_raddr = '0;
    logic [12:0]      rec_rdata;

    int n_chk = 0;
    int n_fail = 0;
    logic [12:0] exp_rec [DEPTH];
    int          n_rec = 0;
    logic        err_exp = 1'b0;

    always #2.5 clk = ~clk;

    l2_decision_ctrl #(.DLY_W(DLY_W), .TO_W(TO_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .l1a_valid(l1a_valid), .l1a_buf(l1a_buf), .l1a_bunch(l1a_bunch),
        .dec_valid(dec_valid), .dec_buf(dec_buf), .dec_bunch(dec_bunch), .dec_pass(dec_pass),
        .delay_cfg(delay_cfg), .timeout_cfg(timeout_cfg),
        .sup_req(sup_req), .sup_code(sup_code), .sup_ack(sup_ack),
        .err_flag(err_flag), .rec_raddr(rec_raddr), .rec_rdata(rec_rdata)
    );

    // fields: order[29:28] l1buf[27:26] l1bx[25:18] dbuf[17:16] dbx[15:8]
    //         pass[7] dly[6:3] code[2:1] err[0]
    // order: 0 accept first, 1 decision first, 2 together, 3 accept only
    localparam logic [29:0] TBL [0:7] = '{
        {2'd0, 2'd1, 8'h10, 2'd1, 8'h10, 1'b1, 4'd0,  2'b01, 1'b0},
        {2'd1, 2'd2, 8'h20, 2'd2, 8'h20, 1'b0, 4'd3,  2'b10, 1'b0},
        {2'd2, 2'd3, 8'hFF, 2'd3, 8'hFF, 1'b1, 4'd7,  2'b01, 1'b0},
        {2'd0, 2'd0, 8'h05, 2'd1, 8'h05, 1'b1, 4'd2,  2'b10, 1'b1},
        {2'd3, 2'd2, 8'h33, 2'd2, 8'h33, 1'b1, 4'd0,  2'b11, 1'b0},
        {2'd1, 2'd1, 8'h40, 2'd1, 8'h41, 1'b1, 4'd1,  2'b10, 1'b1},
        {2'd2, 2'd0, 8'h00, 2'd0, 8'h00, 1'b1, 4'd15, 2'b01, 1'b0},
        {2'd0, 2'd3, 8'h80, 2'd3, 8'h80, 1'b0, 4'd0,  2'b10, 1'b0}
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic set_l1(input logic [1:0] b, input logic [7:0] x);
        l1a_buf = b; l1a_bunch = x; l1a_valid = 1'b1;
    endtask

    task automatic set_dec(input logic [1:0] b, input logic [7:0] x, input logic p);
        dec_buf = b; dec_bunch = x; dec_pass = p; dec_valid = 1'b1;
    endtask

    // count edges until sup_req is seen, starting at the negedge after the entry edge
    task automatic wait_req(output int n);
        n = 0;
        while (!sup_req && n < 200) begin
            tick;
            n++;
        end
    endtask

    // hold, acknowledge, release; records expectation
    task automatic finish_handshake(input string tag, input logic [1:0] code,
                                    input logic [1:0] b, input logic [7:0] x, input logic e);
        logic [1:0] first_code;
        first_code = sup_code;
        chk({tag, " R5 code"}, sup_code, code);
        tick; tick; tick;
        chk({tag, " R7 held"}, {sup_req, sup_code}, {1'b1, first_code});
        sup_ack = 1'b1;
        tick;
        chk({tag, " R7 drop"}, sup_req, 1'b0);
        err_exp = err_exp | e;
        chk({tag, " R6 err"}, err_flag, err_exp);
        exp_rec[n_rec] = {b, x, code, e};
        n_rec++;
        sup_ack = 1'b0;
        tick;
        tick;
    endtask

    initial begin
        #(100000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat;
        logic any_req;
        @(negedge clk);
        tick; tick;
        chk("R1 reset req", sup_req, 1'b0);
        chk("R1 reset code", sup_code, 2'b00);
        chk("R1 reset err", err_flag, 1'b0);
        rst_n = 1'b1;
        tick;

        // vector table walk
        for (int i = 0; i < 8; i++) begin
            logic [29:0] v;
            int need;
            v = TBL[i];
            delay_cfg = DLY_W'(v[6:3]);
            case (v[29:28])
                2'd0: begin
                    set_l1(v[27:26], v[25:18]); tick; l1a_valid = 1'b0;
                    tick;
                    chk("R2 accept only", sup_req, 1'b0);
                    set_dec(v[17:16], v[15:8], v[7]); tick; dec_valid = 1'b0;
                end
                2'd1: begin
                    set_dec(v[17:16], v[15:8], v[7]); tick; dec_valid = 1'b0;
                    tick;
                    chk("R2 decision only", sup_req, 1'b0);
                    set_l1(v[27:26], v[25:18]); tick; l1a_valid = 1'b0;
                end
                2'd2: begin
                    set_l1(v[27:26], v[25:18]);
                    set_dec(v[17:16], v[15:8], v[7]);
                    tick; l1a_valid = 1'b0; dec_valid = 1'b0;
                end
                default: begin
                    set_l1(v[27:26], v[25:18]); tick; l1a_valid = 1'b0;
                end
            endcase
            need = (v[29:28] == 2'd3) ? TO_SET + 1 : int'(v[6:3]) + 1;
            wait_req(lat);
            chk((v[29:28] == 2'd3) ? "R4 timeout latency" : "R3 delay latency", lat, need);
            finish_handshake("table", v[2:1], v[27:26], v[25:18], v[0]);
        end

        // R4: decision on the expiry edge wins over the timeout
        delay_cfg = '0;
        set_l1(2'd1, 8'h77); tick; l1a_valid = 1'b0;
        for (int k = 0; k < TO_SET; k++) tick;
        set_dec(2'd1, 8'h77, 1'b1); tick; dec_valid = 1'b0;
        wait_req(lat);
        chk("R4 priority latency", lat, 1);
        finish_handshake("R4 priority", 2'b01, 2'd1, 8'h77, 1'b0);

        // R2: a decision alone never produces an outcome
        set_dec(2'd2, 8'h9A, 1'b1); tick; dec_valid = 1'b0;
        any_req = 1'b0;
        for (int k = 0; k < 30; k++) begin tick; any_req |= sup_req; end
        chk("R2 lone decision", any_req, 1'b0);
        delay_cfg = 8'd2;
        set_l1(2'd2, 8'h9A); tick; l1a_valid = 1'b0;
        wait_req(lat);
        chk("R3 late accept latency", lat, 3);
        finish_handshake("R2 late accept", 2'b01, 2'd2, 8'h9A, 1'b0);

        // R8: inputs during release are ignored
        delay_cfg = '0;
        set_l1(2'd3, 8'h5C); set_dec(2'd3, 8'h5C, 1'b0);
        tick; l1a_valid = 1'b0; dec_valid = 1'b0;
        wait_req(lat);
        chk("R5 reject code", sup_code, 2'b10);
        sup_ack = 1'b1;
        tick;
        set_l1(2'd0, 8'h11); set_dec(2'd0, 8'h11, 1'b1);
        tick; l1a_valid = 1'b0; dec_valid = 1'b0;
        tick;
        sup_ack = 1'b0;
        exp_rec[n_rec] = {2'd3, 8'h5C, 2'b10, 1'b0};
        n_rec++;
        any_req = 1'b0;
        for (int k = 0; k < 20; k++) begin tick; any_req |= sup_req; end
        chk("R8 ignored during release", any_req, 1'b0);

        // R9: read back every record
        for (int a = 0; a < n_rec; a++) begin
            rec_raddr = AW'(a);
            tick;
            chk($sformatf("R9 record %0d", a), rec_rdata, exp_rec[a]);
        end

        // R1/R6: reset clears the sticky flag
        chk("R6 err still set", err_flag, 1'b1);
        rst_n = 1'b0;
        tick;
        chk("R6 err cleared by reset", err_flag, 1'b0);
        chk("R1 req after reset", sup_req, 1'b0);
        rst_n = 1'b1;
        tick;

        finish_run();
    end
endmodule